// File: doc/BRIEF.md
# Two-wire Register Slave with Shadow Bank

This block is the target of a two-wire serial bus that lets an external microcontroller read and write a 256-byte register space. The slave keeps an address pointer after each transaction, so a read with no word address continues from where the last access stopped. A word address set in a short write, followed by a repeated START, reads any location. A master acknowledge asks for the next byte. The open-drain data line is split into an input, an output that is always low and an output enable. Both bus lines are resampled in the system clock domain.

A fixed window of registers can be double-buffered. When buffering is on, bus writes to the window go only to a shadow copy. A command bit copies the whole window to the active registers in one cycle. Sixteen event inputs set sticky flags that are cleared by writing ones. A mask register pair selects which flags drive the interrupt output. All active register values are brought out as one flat vector for the rest of the chip.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges only an address byte of 0x74 (write) or 0x75 (read), which is the 7-bit address 0x3A followed by the R/W bit. Any other address gets no acknowledge and changes no register.
- R2: After reset the data line is released, irq_o is low and every register reads 0. A START (SDA falls while SCL is high) begins a new transfer from any state. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is acknowledged, stored at the pointer, and then the pointer increments by one, wrapping from FFh to 00h.
- R4: A read that is not preceded by a word address returns the byte at the last accessed address plus one.
- R5: A write carrying only a word address, followed by a repeated START and a read address, returns data starting at that word address.
- R6: While reading, each master ACK returns the next byte (pointer plus one). A master NACK ends the transfer with SDA released.
- R7: With bit 4 of register C1h set, writes to 10h–1Fh update only the shadow copy, and the active register and its read value stay unchanged. With bit 4 clear, such writes update both.
- R8: Writing C1h with bit 1 or bit 0 set copies all of 10h–1Fh from the shadow to the active registers. Those two bits always read back as 0.
- R9: Flag bit i (E8h holds events 7..0, E9h holds events 15..8) is set on any clock where evt_i[i] is high. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged.
- R10: If an event is high in the same cycle as a clear of its flag, the flag stays set.
- R11: irq_o is high exactly when some flag bit is set and its enable bit is set. Enable bit i lives at EAh (events 7..0) and EBh (events 15..8).
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Data drive value, constant low |
| sda_oe | output | 1 | Pulls SDA low when high |
| evt_i | input | 16 | Event inputs that set the interrupt flags |
| act_o | output | 2048 | Active register values, byte n at bits 8n+7..8n |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the bus obeys the protocol. The master holds SDA steady while SCL is high, except to form START or STOP. It never issues a START or STOP while the slave is pulling SDA low. Each SCL phase lasts longer than the two-flop resampling delay. The bench master keeps every quarter bit period at eight system clocks. It changes SDA only after SCL has been low for that long, and it releases SDA before every acknowledge that the slave drives. Events change only between transactions, except in the held-event test of R10, where one input stays high across the whole clearing write.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int SHD_LO = 16,
  parameter int SHD_HI = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          sda_oe,
  input  logic [15:0]   evt_i,
  output logic [2047:0] act_o,
  output logic          irq_o
);
  localparam int SHD_N = SHD_HI - SHD_LO + 1;
  localparam int SW = (SHD_N > 1) ? $clog2(SHD_N) : 1;
  localparam logic [7:0] LO8 = 8'(SHD_LO);
  localparam logic [7:0] HI8 = 8'(SHD_HI);
  localparam logic [7:0] A_CTRL = 8'hC1, A_FLG0 = 8'hE8, A_FLG1 = 8'hE9, A_EN0 = 8'hEA, A_EN1 = 8'hEB;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WBYTE, S_TX, S_MACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        st;
  logic [2:0] cnt;
  logic       got, rw, first, nack;
  logic [7:0] sh, tx, ptr, ptr_data;
  logic       wr_en, commit_q;
  logic [7:0] wr_a, wr_d;
  logic [7:0] mem [256];
  logic [7:0] shd [SHD_N];
  logic [15:0] flags, clr;

  assign sda_o = 1'b0;
  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign ptr_data = (ptr == A_FLG0) ? flags[7:0] : (ptr == A_FLG1) ? flags[15:8] : mem[ptr];
  assign irq_o = |(flags & {mem[A_EN1], mem[A_EN0]});
  assign clr = {(wr_en && wr_a == A_FLG1) ? wr_d : 8'h00, (wr_en && wr_a == A_FLG0) ? wr_d : 8'h00};

  function automatic logic in_rng(input logic [7:0] a);
    return (a >= LO8) && (a <= HI8);
  endfunction

  for (genvar g = 0; g < 256; g++) begin : g_act
    if (g == 232)      begin : g_f0 assign act_o[8*g +: 8] = flags[7:0];  end
    else if (g == 233) begin : g_f1 assign act_o[8*g +: 8] = flags[15:8]; end
    else               begin : g_m  assign act_o[8*g +: 8] = mem[g];      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; got <= 1'b0; rw <= 1'b0; first <= 1'b0; nack <= 1'b0;
      sh <= '0; tx <= '0; ptr <= '0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_a <= '0; wr_d <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; got <= 1'b0; first <= 1'b1; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WBYTE: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1; rw <= sh[0]; st <= S_ACK;
                end else st <= S_IDLE;
              end else begin
                sda_oe <= 1'b1;
                st <= S_ACK;
                if (first) begin
                  ptr <= sh; first <= 1'b0;
                end else begin
                  wr_en <= 1'b1; wr_a <= ptr; wr_d <= sh; ptr <= ptr + 8'd1;
                end
              end
            end
          end
          S_ACK, S_MACK: begin
            if (st == S_MACK && scl_rise) nack <= sda_s;
            if (scl_fall) begin
              if (st == S_MACK && nack) begin
                sda_oe <= 1'b0; st <= S_IDLE;
              end else if (rw) begin
                tx <= ptr_data; sda_oe <= ~ptr_data[7]; cnt <= '0; st <= S_TX;
              end else begin
                sda_oe <= 1'b0; st <= S_WBYTE;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0; st <= S_MACK; ptr <= ptr + 8'd1;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 3'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      for (int i = 0; i < SHD_N; i++) shd[i] <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (wr_en && wr_a != A_FLG0 && wr_a != A_FLG1) begin
        if (wr_a == A_CTRL) begin
          mem[A_CTRL] <= wr_d & 8'hFC;
          commit_q <= |wr_d[1:0];
        end else if (in_rng(wr_a)) begin
          shd[SW'(wr_a - LO8)] <= wr_d;
          if (!mem[A_CTRL][4]) mem[wr_a] <= wr_d;
        end else mem[wr_a] <= wr_d;
      end
      if (commit_q)
        for (int i = 0; i < SHD_N; i++) mem[LO8 + 8'(i)] <= shd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | evt_i;
  end

  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));
  a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(evt_i)) == 16'h0);
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));
  a_r8_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic [15:0] evt = '0;
  logic sda_o, sda_oe, irq;
  logic [2047:0] act;
  wire sda_line = msda & ~sda_oe;

  i2c_regbank_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .evt_i(evt), .act_o(act), .irq_o(irq));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, cmp_en = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_shd [256];
  logic [15:0] m_flg = '0;
  logic [7:0] m_ptr = '0;
  logic [7:0] wbuf [$];

  task automatic chk(input string req, input logic [2047:0] got, input logic [2047:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [7:0] a);
    if (a == 8'hE8) return m_flg[7:0];
    if (a == 8'hE9) return m_flg[15:8];
    return m_mem[a];
  endfunction

  function automatic void m_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hE8) m_flg = (m_flg & ~{8'h00, d}) | evt;
    else if (a == 8'hE9) m_flg = (m_flg & ~{d, 8'h00}) | evt;
    else if (a == 8'hC1) begin
      m_mem[a] = d & 8'hFC;
      if (d[1:0] != 0) for (int i = 16; i < 32; i++) m_mem[i] = m_shd[i];
    end else if (a >= 8'h10 && a <= 8'h1F) begin
      m_shd[a] = d;
      if (!m_mem[8'hC1][4]) m_mem[a] = d;
    end else m_mem[a] = d;
  endfunction

  function automatic logic [2047:0] m_vec();
    logic [2047:0] v;
    for (int i = 0; i < 256; i++) v[8*i +: 8] = m_rd(8'(i));
    return v;
  endfunction

  always @(negedge clk) if (cmp_en && !done) begin
    chk("R3/R7 active map", act, m_vec());
    chk("R11 irq", {2047'b0, irq}, {2047'b0, |(m_flg & {m_mem[8'hEB], m_mem[8'hEA]})});
  end

  always @(sda_oe) if (rst_n && !done) begin
    chk("R12 drive while scl low", {2047'b0, scl}, 2048'b0);
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; qw(); scl = 1'b1; qw(); scl = 1'b0; qw();
    end
    msda = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; scl = 1'b0; qw();
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    msda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl = 1'b1; qw(); b = {b[6:0], sda_line}; scl = 1'b0;
    end
    qw(); msda = ~mack; qw(); scl = 1'b1; qw(); scl = 1'b0; qw(); msda = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk); cmp_en = 1;
  endtask

  task automatic wr_txn(input logic [7:0] wa);
    logic ack;
    cmp_en = 0;
    bus_start();
    send(8'h74, ack); chk("R1 write address ack", {2047'b0, ack}, {2047'b0, 1'b1});
    send(wa, ack); m_ptr = wa;
    foreach (wbuf[i]) begin
      send(wbuf[i], ack);
      chk("R3 data ack", {2047'b0, ack}, {2047'b0, 1'b1});
      m_wr(m_ptr, wbuf[i]); m_ptr = m_ptr + 8'd1;
    end
    bus_stop();
    wbuf.delete();
    settle();
  endtask

  task automatic rd_txn(input bit set_addr, input logic [7:0] wa, input int n, input string req);
    logic ack;
    logic [7:0] b;
    cmp_en = 0;
    if (set_addr) begin
      bus_start(); send(8'h74, ack); send(wa, ack); m_ptr = wa;
    end
    bus_start();
    send(8'h75, ack); chk("R1 read address ack", {2047'b0, ack}, {2047'b0, 1'b1});
    for (int i = 0; i < n; i++) begin
      recv(b, i != n - 1);
      chk(req, {2040'b0, b}, {2040'b0, m_rd(m_ptr)});
      m_ptr = m_ptr + 8'd1;
    end
    bus_stop();
    chk("R6 bus released after nack", {2047'b0, sda_oe}, 2048'b0);
    settle();
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    cmp_en = 0;
    @(negedge clk) evt = v;
    @(negedge clk) evt = '0;
    m_flg = m_flg | v;
    settle();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_shd[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset sda released", {2047'b0, sda_oe}, 2048'b0);
    chk("R2 reset registers", act, 2048'b0);
    cmp_en = 1;

    cmp_en = 0;
    bus_start(); send(8'h50, ack); send(8'h40, ack); bus_stop();
    chk("R1 foreign address ignored", {2047'b0, ack}, 2048'b0);
    settle();

    wbuf = '{8'hA1, 8'hB2, 8'hC3}; wr_txn(8'h40);
    rd_txn(1, 8'h40, 3, "R5/R6 random then sequential read");

    wbuf = '{8'h11, 8'h22, 8'h33}; wr_txn(8'h60);
    wbuf = '{8'h44}; wr_txn(8'h60);
    rd_txn(0, 8'h00, 1, "R4 current address read");

    wbuf = '{8'h5E, 8'h6F}; wr_txn(8'hFF);
    rd_txn(1, 8'hFF, 2, "R3 pointer wrap");

    wbuf = '{8'h07}; wr_txn(8'h10);
    wbuf = '{8'h10}; wr_txn(8'hC1);
    wbuf = '{8'h99, 8'h88}; wr_txn(8'h10);
    rd_txn(1, 8'h10, 2, "R7 shadowed write hidden");
    wbuf = '{8'h13}; wr_txn(8'hC1);
    rd_txn(1, 8'h10, 2, "R8 commit copied shadow");
    rd_txn(1, 8'hC1, 1, "R8 commit bits read 0");

    pulse_evt(16'h8001);
    rd_txn(1, 8'hE8, 2, "R9 flags read");
    wbuf = '{8'h01}; wr_txn(8'hEA);
    chk("R11 irq enabled", {2047'b0, irq}, {2047'b0, 1'b1});
    wbuf = '{8'h00}; wr_txn(8'hE8);
    rd_txn(1, 8'hE8, 1, "R9 write zero keeps flag");
    wbuf = '{8'h01}; wr_txn(8'hE8);
    chk("R11 irq after clear", {2047'b0, irq}, 2048'b0);

    cmp_en = 0;
    @(negedge clk) evt = 16'h8000;
    wbuf = '{8'h80}; wr_txn(8'hE9);
    cmp_en = 0;
    @(negedge clk) evt = '0;
    settle();
    rd_txn(1, 8'hE9, 1, "R10 event beats clear");
    wbuf = '{8'h80}; wr_txn(8'hE9);
    rd_txn(1, 8'hE9, 1, "R9 flag cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule